// File: doc/BRIEF.md
# LCD Raster Controller Control and Status Unit

This unit owns the control and status registers of a simple LCD raster controller. Software reaches it through a synchronous register port with separate write and read strobes. From the control word it drives a run signal, a panel-type select, a two-bit load-mode field and a line-interrupt clear-select bit to the raster engine. The engine reports its events back to the unit as one-cycle pulses: end of frame, vsync, sync lost, AC-bias count, line match, FIFO underflow and palette loaded.

Events are collected into sticky status flags. A single interrupt line is raised when any enabled flag is set. Clearing the enable bit does not halt the engine at once. The engine keeps running until the current frame ends, and only then does the unit drop run and raise the done flag. Each flag has its own clearing rule. Some are cleared by writing zero to them. Sync lost and underflow are cleared when the controller is disabled. Done is cleared when the controller is enabled again. Palette loaded is cleared by a write or by a disable, depending on the load mode.

The register port takes one access per cycle and never stalls, so it needs no back-pressure. A write takes effect at the clock edge where it is sampled. Read data appears on the cycle after the read strobe and holds until the next read. The window has eight 32-bit words, selected by address bits [4:2]. An access is ignored if address bits [1:0] or [7:5] are nonzero. Such a read returns zero.

Top module: `lcd_ctl_regs`

## Requirements
- R1: After reset every register word reads zero, and run, interrupt, panel select, load mode and clear select are all low.
- R2: The control word (offset 0x00) stores bit 0 (enable), bits 2..6 (interrupt enables: vsync, done, palette, line-alternate, line), bit 7 (active-matrix panel), bit 10 (line clear select) and bits [21:20] (load mode: 00 palette+frame, 01 palette only, 10 frame only). All other bits read zero. Bit 7, bit 10 and bits [21:20] drive the panel-select, clear-select and load-mode outputs.
- R3: A control write with bit 0 set while the unit is idle makes run high on the next cycle and clears done (status bit 0).
- R4: A control write with bit 0 clear while running starts a drain. Run stays high and end-of-frame pulses are otherwise ignored until the first end-of-frame pulse in the drain. After that pulse, run is low and done is set on the next cycle.
- R5: A control write with bit 0 set during a drain cancels the stop, even if an end-of-frame pulse arrives in the same cycle. Run stays high and done stays clear.
- R6: Status flags at offset 0x10 are sticky. They are bit 0 done, bit 1 vsync, bit 2 sync lost, bit 3 AC-bias, bit 4 line, bit 5 underflow and bit 6 palette loaded. An event pulse sets its flag on the next cycle.
- R7: Writing zero to status bits 1, 3 or 4 clears them. Writing one leaves them unchanged. Status writes never change bits 0, 2 or 5.
- R8: Palette loaded (bit 6) is cleared by a status write of zero only while the load mode is 01. In any other load mode it is cleared by a disable.
- R9: A disable, meaning a control write with bit 0 clear while running, clears sync lost and underflow.
- R10: An event pulse wins over a clear that happens in the same cycle, so the flag ends up set.
- R11: The interrupt output is high when any of these holds: done with enable bit 3, vsync with bit 2, palette with bit 4, line with bit 5 or bit 6, sync lost, or underflow. The AC-bias flag never raises it.
- R12: Words at 0x04, 0x08, 0x0C, 0x14 and 0x18 are plain full-width read/write storage. Word 0x1C is read-only and shows run in bit 0 and draining in bit 1. Writes to 0x1C are ignored.
- R13: Read data appears on the cycle after the read strobe and reflects the state before any write in that same cycle. It holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_frame_end | input | 1 | End-of-frame pulse from raster engine |
| evt_vsync | input | 1 | Vsync pulse |
| evt_sync_lost | input | 1 | Sync-lost pulse |
| evt_acb | input | 1 | AC-bias count pulse |
| evt_line | input | 1 | Line match pulse |
| evt_underflow | input | 1 | FIFO underflow pulse |
| evt_pal_loaded | input | 1 | Palette-loaded pulse |
| ctl_run | output | 1 | Raster engine run request |
| ctl_tft | output | 1 | Active-matrix panel select |
| ctl_load_mode | output | 2 | Load mode to the engine |
| ctl_line_clr_sel | output | 1 | Line interrupt clear select |
| irq | output | 1 | Interrupt request |

## Verification
Every state change is due exactly one rising edge after the stimulus. Writes, event pulses, run and draining transitions, and flag updates all follow this rule. The interrupt output follows the flags and enables combinationally, so it also changes one edge after the event or write. Read data is due one edge after the read strobe and carries the values from before that edge. The bench applies stimulus on the falling edge, advances its own model by one step, and compares every output at the next falling edge. This lands each check in the first cycle where the result is due.

// File: rtl/lcd_ctl_pkg.sv
package lcd_ctl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} run_st_t;

  // word indices within the register window
  localparam int W_CTL  = 0;
  localparam int W_STS  = 4;
  localparam int W_DISP = 7;

  // control bit positions (decoded by the raster engine and software)
  localparam int C_EN      = 0;
  localparam int C_IE_VS   = 2;
  localparam int C_IE_DONE = 3;
  localparam int C_IE_PAL  = 4;
  localparam int C_IE_LNA  = 5;
  localparam int C_IE_LN   = 6;
  localparam int C_TFT     = 7;
  localparam int C_LCLR    = 10;
  localparam int C_MODE_LO = 20;

  // status flag positions
  localparam int S_DONE = 0;
  localparam int S_VS   = 1;
  localparam int S_SL   = 2;
  localparam int S_ACB  = 3;
  localparam int S_LN   = 4;
  localparam int S_UF   = 5;
  localparam int S_PAL  = 6;
  localparam int NFLAG  = 7;

  localparam logic [1:0] MODE_PAL_ONLY = 2'b01;

  function automatic logic is_aux_word(input int w);
    return (w == 1) || (w == 2) || (w == 3) || (w == 5) || (w == 6);
  endfunction
endpackage

// File: rtl/lcd_ctl_seq.sv
module lcd_ctl_seq
  import lcd_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic en_wdata,
  input  logic frame_end,
  output logic start,
  output logic stop,
  output logic finish,
  output logic running,
  output logic draining
);
  run_st_t st_q, st_d;
  logic    cancel;

  assign start  = ctl_wr &  en_wdata & (st_q == ST_IDLE);
  assign stop   = ctl_wr & ~en_wdata & (st_q == ST_RUN);
  assign cancel = ctl_wr &  en_wdata & (st_q == ST_DRAIN);
  assign finish = (st_q == ST_DRAIN) & ~cancel & frame_end;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_RUN;
      ST_RUN:   if (stop) st_d = ST_DRAIN;
      ST_DRAIN: begin
        if (cancel)      st_d = ST_RUN;
        else if (finish) st_d = ST_IDLE;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;

  assign running  = (st_q != ST_IDLE);
  assign draining = (st_q == ST_DRAIN);
endmodule

// File: rtl/lcd_ctl_flags.sv
module lcd_ctl_flags
  import lcd_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_v,
  input  logic             start,
  input  logic             stop,
  input  logic             sts_wr,
  input  logic [NFLAG-1:0] sts_wdata,
  input  logic             pal_only,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] clr_v;
  logic             w0c;

  always_comb begin
    w0c          = 1'b0;
    clr_v        = '0;
    clr_v[S_DONE] = start;
    clr_v[S_VS]   = sts_wr & ~sts_wdata[S_VS];
    clr_v[S_ACB]  = sts_wr & ~sts_wdata[S_ACB];
    clr_v[S_LN]   = sts_wr & ~sts_wdata[S_LN];
    clr_v[S_SL]   = stop;
    clr_v[S_UF]   = stop;
    w0c           = sts_wr & ~sts_wdata[S_PAL];
    clr_v[S_PAL]  = pal_only ? w0c : stop;
  end

  for (genvar b = 0; b < NFLAG; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        flags[b] <= 1'b0;
      else if (set_v[b]) flags[b] <= 1'b1;
      else if (clr_v[b]) flags[b] <= 1'b0;
  end
endmodule

// File: rtl/lcd_ctl_aux.sv
module lcd_ctl_aux
  import lcd_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val
);
  localparam int NWORD = 1 << WORD_W;
  logic [DATA_W-1:0] words [NWORD];

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    if (is_aux_word(w)) begin : g_store
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                                words[w] <= '0;
        else if (wr && (word == WORD_W'(w)))       words[w] <= wdata;
    end else begin : g_none
      assign words[w] = '0;
    end
  end

  assign rd_val = words[word];
endmodule

// File: rtl/lcd_ctl_regs.sv
module lcd_ctl_regs
  import lcd_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_frame_end,
  input  logic              evt_vsync,
  input  logic              evt_sync_lost,
  input  logic              evt_acb,
  input  logic              evt_line,
  input  logic              evt_underflow,
  input  logic              evt_pal_loaded,
  output logic              ctl_run,
  output logic              ctl_tft,
  output logic [1:0]        ctl_load_mode,
  output logic              ctl_line_clr_sel,
  output logic              irq
);
  localparam int BYTE_OFS = $clog2(DATA_W / 8);
  localparam int WORD_W   = 3;
  localparam logic [DATA_W-1:0] CTL_MASK =
      (DATA_W'(1) << C_EN) | (DATA_W'(5'h1f) << C_IE_VS) | (DATA_W'(1) << C_TFT) |
      (DATA_W'(1) << C_LCLR) | (DATA_W'(2'b11) << C_MODE_LO);

  logic              hit, ctl_wr, sts_wr;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] ctl_q, aux_rd, rd_mux;
  logic              start, stop, finish, running, draining;
  logic [NFLAG-1:0]  flags, set_v;

  assign hit    = (bus_addr[ADDR_W-1:BYTE_OFS+WORD_W] == '0) &&
                  (bus_addr[BYTE_OFS-1:0] == '0);
  assign word   = bus_addr[BYTE_OFS+WORD_W-1:BYTE_OFS];
  assign ctl_wr = bus_wr & hit & (word == WORD_W'(W_CTL));
  assign sts_wr = bus_wr & hit & (word == WORD_W'(W_STS));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= bus_wdata & CTL_MASK;

  lcd_ctl_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .en_wdata (bus_wdata[C_EN]),
    .frame_end(evt_frame_end),
    .start    (start),
    .stop     (stop),
    .finish   (finish),
    .running  (running),
    .draining (draining)
  );

  always_comb begin
    set_v         = '0;
    set_v[S_DONE] = finish;
    set_v[S_VS]   = evt_vsync;
    set_v[S_SL]   = evt_sync_lost;
    set_v[S_ACB]  = evt_acb;
    set_v[S_LN]   = evt_line;
    set_v[S_UF]   = evt_underflow;
    set_v[S_PAL]  = evt_pal_loaded;
  end

  lcd_ctl_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_v    (set_v),
    .start    (start),
    .stop     (stop),
    .sts_wr   (sts_wr),
    .sts_wdata(bus_wdata[NFLAG-1:0]),
    .pal_only (ctl_q[C_MODE_LO+1:C_MODE_LO] == MODE_PAL_ONLY),
    .flags    (flags)
  );

  lcd_ctl_aux #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_aux (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr & hit),
    .word  (word),
    .wdata (bus_wdata),
    .rd_val(aux_rd)
  );

  always_comb begin
    case (word)
      WORD_W'(W_CTL):  rd_mux = ctl_q;
      WORD_W'(W_STS):  rd_mux = DATA_W'(flags);
      WORD_W'(W_DISP): rd_mux = DATA_W'({draining, running});
      default:         rd_mux = aux_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= hit ? rd_mux : '0;

  assign ctl_run          = running;
  assign ctl_tft          = ctl_q[C_TFT];
  assign ctl_load_mode    = ctl_q[C_MODE_LO+1:C_MODE_LO];
  assign ctl_line_clr_sel = ctl_q[C_LCLR];

  assign irq = (flags[S_DONE] & ctl_q[C_IE_DONE]) |
               (flags[S_VS]   & ctl_q[C_IE_VS])   |
               (flags[S_PAL]  & ctl_q[C_IE_PAL])  |
               (flags[S_LN]   & (ctl_q[C_IE_LNA] | ctl_q[C_IE_LN])) |
               flags[S_SL] | flags[S_UF];
endmodule

// File: rtl/lcd_ctl_regs_chk.sv
module lcd_ctl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              evt_frame_end,
  input logic              evt_vsync,
  input logic              evt_sync_lost,
  input logic              ctl_run,
  input logic              irq,
  input logic [6:0]        flags
);
  a_r3_enable_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata[0] && !ctl_run) |=> (ctl_run && !flags[0]));

  a_r4_run_ends_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_run) |-> $past(evt_frame_end));

  a_r4_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($past(evt_frame_end) && $past(ctl_run)));

  a_r6_vsync_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vsync |=> flags[1]);

  a_r10_sync_lost_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sync_lost |=> flags[2]);

  a_r11_fault_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] || flags[5]) |-> irq);

  a_r13_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind lcd_ctl_regs lcd_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/lcd_ctl_regs_test.sv
module lcd_ctl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  ev = '0;
  logic        ctl_run, ctl_tft, ctl_line_clr_sel, irq;
  logic [1:0]  ctl_load_mode;

  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  logic [31:0] m_ctl = '0, m_rd = '0;
  logic [6:0]  m_fl = '0;
  int          m_st = 0;
  logic [31:0] m_aux [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_frame_end(ev[0]), .evt_vsync(ev[1]), .evt_sync_lost(ev[2]),
    .evt_acb(ev[3]), .evt_line(ev[4]), .evt_underflow(ev[5]),
    .evt_pal_loaded(ev[6]), .ctl_run(ctl_run), .ctl_tft(ctl_tft),
    .ctl_load_mode(ctl_load_mode), .ctl_line_clr_sel(ctl_line_clr_sel), .irq(irq)
  );

  function automatic logic [31:0] m_read(input int w);
    case (w)
      0: return m_ctl;
      4: return {25'b0, m_fl};
      7: return {30'b0, m_st == 2, m_st != 0};
      1, 2, 3, 5, 6: return m_aux[w];
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic m_irq();
    return (m_fl[0] & m_ctl[3]) | (m_fl[1] & m_ctl[2]) | (m_fl[6] & m_ctl[4]) |
           (m_fl[4] & (m_ctl[5] | m_ctl[6])) | m_fl[2] | m_fl[5];
  endfunction

  task automatic chk(input string tag, input string req, input string nm,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s actual=%h expected=%h", tag, req, nm, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, advance model, compare at next falling edge
  task automatic cyc(input string tag, input logic wr, input logic rd,
                     input int w, input logic [31:0] d, input logic [6:0] e);
    logic ctl_w, sts_w, start, stop, cancel, finish, pclr;
    logic [6:0] nf;
    bus_wr = wr; bus_rd = rd; bus_addr = 8'(w << 2); bus_wdata = d; ev = e;
    ctl_w  = wr && (w == 0);
    sts_w  = wr && (w == 4);
    start  = ctl_w &&  d[0] && (m_st == 0);
    stop   = ctl_w && !d[0] && (m_st == 1);
    cancel = ctl_w &&  d[0] && (m_st == 2);
    finish = (m_st == 2) && !cancel && e[0];
    if (rd) m_rd = m_read(w);
    nf = m_fl;
    if (start) nf[0] = 1'b0;
    if (sts_w && !d[1]) nf[1] = 1'b0;
    if (sts_w && !d[3]) nf[3] = 1'b0;
    if (sts_w && !d[4]) nf[4] = 1'b0;
    if (stop) begin nf[2] = 1'b0; nf[5] = 1'b0; end
    pclr = (m_ctl[21:20] == 2'b01) ? (sts_w && !d[6]) : stop;
    if (pclr) nf[6] = 1'b0;
    nf = nf | {e[6:1], finish};
    m_fl = nf;
    if (ctl_w) m_ctl = d & 32'h0030_04FD;
    if (wr && (w == 1 || w == 2 || w == 3 || w == 5 || w == 6)) m_aux[w] = d;
    if (start || cancel) m_st = 1;
    else if (stop) m_st = 2;
    else if (finish) m_st = 0;
    @(negedge clk);
    chk(tag, "R4", "run", 32'(ctl_run), 32'(m_st != 0));
    chk(tag, "R11", "irq", 32'(irq), 32'(m_irq()));
    chk(tag, "R2", "tft", 32'(ctl_tft), 32'(m_ctl[7]));
    chk(tag, "R2", "mode", 32'(ctl_load_mode), 32'(m_ctl[21:20]));
    chk(tag, "R2", "lclr", 32'(ctl_line_clr_sel), 32'(m_ctl[10]));
    chk(tag, "R13", "rdata", bus_rdata, m_rd);
  endtask

  task automatic wr_(input string tag, input int w, input logic [31:0] d);
    cyc(tag, 1'b1, 1'b0, w, d, 7'b0);
  endtask
  task automatic rd_(input string tag, input int w);
    cyc(tag, 1'b0, 1'b1, w, 32'b0, 7'b0);
  endtask
  task automatic ev_(input string tag, input logic [6:0] e);
    cyc(tag, 1'b0, 1'b0, 0, 32'b0, e);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_aux[i] = '0;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values on every word
    for (int w = 0; w < 8; w++) rd_("R1", w);
    // R2: control fields and masking
    wr_("R2", 0, 32'hFFFF_FFFE); rd_("R2", 0);
    wr_("R2", 0, 32'h0010_0000); rd_("R2", 0);
    // R3: start
    wr_("R3", 0, 32'h0020_0009); rd_("R3", 7);
    // R4: frame end while running ignored; drain then finish
    ev_("R4", 7'b000_0001);
    wr_("R4", 0, 32'h0020_0008);
    ev_("R4", 7'b0); rd_("R4", 7);
    ev_("R4", 7'b000_0001); rd_("R4", 4); rd_("R4", 7);
    // R3: re-enable clears done
    wr_("R3", 0, 32'h0020_0001); rd_("R3", 4);
    // R5: cancel during drain, with end of frame in same cycle
    wr_("R5", 0, 32'h0020_0000);
    cyc("R5", 1'b1, 1'b0, 0, 32'h0020_0001, 7'b000_0001);
    ev_("R5", 7'b000_0001); rd_("R5", 4);
    // R6: sticky flags
    ev_("R6", 7'b111_1110); ev_("R6", 7'b0); rd_("R6", 4);
    // R7: write-zero clears 1,3,4 only
    wr_("R7", 4, 32'h0000_0002); rd_("R7", 4);
    // R10: event beats same-cycle clear
    cyc("R10", 1'b1, 1'b0, 4, 32'h0, 7'b001_0000); rd_("R10", 4);
    // R8: palette flag not cleared by write in frame-only mode, cleared by disable
    wr_("R8", 4, 32'h0); rd_("R8", 4);
    // R9: disable clears sync lost / underflow (and palette in this mode)
    wr_("R9", 0, 32'h0020_0000); rd_("R9", 4);
    ev_("R9", 7'b000_0001);
    // R8: palette-only mode write clears palette flag
    wr_("R8", 0, 32'h0010_0010); ev_("R8", 7'b100_0000); rd_("R8", 4);
    wr_("R8", 4, 32'h0); rd_("R8", 4);
    // R11: irq enable combinations, AC-bias never raises it
    wr_("R11", 0, 32'h0010_0000); ev_("R11", 7'b000_1000);
    ev_("R11", 7'b001_0000); wr_("R11", 0, 32'h0010_0020); wr_("R11", 0, 32'h0010_0040);
    wr_("R11", 4, 32'h0);
    // R12: aux storage and read-only display word
    wr_("R12", 1, 32'hDEAD_BEEF); wr_("R12", 6, 32'h1234_5678);
    wr_("R12", 7, 32'hFFFF_FFFF); rd_("R12", 1); rd_("R12", 6); rd_("R12", 7);
    // R13: read returns pre-write value, then holds
    cyc("R13", 1'b1, 1'b1, 2, 32'hA5A5_0001, 7'b0); ev_("R13", 7'b0); rd_("R13", 2);
    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic wr, rd;
      int w;
      logic [31:0] d;
      logic [6:0] e;
      wr = ($urandom % 4) == 0;
      rd = ($urandom % 2) == 0;
      w  = $urandom % 8;
      d  = $urandom;
      if (($urandom % 3) == 0) d[21:20] = 2'b01;
      e  = '0;
      for (int b = 1; b < 7; b++) e[b] = ($urandom % 10) == 0;
      e[0] = ($urandom % 6) == 0;
      cyc("RND", wr, rd, w, d, e);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule